// File: doc/BRIEF.md
# Constant-Latency Lossy Hit-to-Link Multiplexer

This block sits behind the discriminators of a segmented-strip sensor. Once every bunch crossing it samples a vector of 31 channel hit flags and sends the indices of the channels that fired over a small bank of parallel address links. Each link carries one channel address and a valid bit. The number of links is fixed at 8. When more channels fire than there are links, the extra hits are thrown away and a loss flag is raised for that crossing. Hits are never queued into a later crossing.

Links are handed out by a running count of used slots. The count travels along the channels in ascending index order. A channel that fired takes the slot the count points at and then increments the count. Once the last slot is taken, an enable bit drops and later channels can write nothing. The channel chain is cut into three register-separated groups: channels 0 to 14, channel 15 alone, and channels 16 to 30. The hit bits of each later group are delayed so that they meet the count of their own crossing. One result therefore leaves the block every clock, always the same number of cycles after its crossing, however many channels fired.

Top module: `hitlink_top`

## Requirements
- R1: While `rstN` is low, `linkValid`, `linkAddr` and `hitLost` are all zero.
- R2: The result for the hit vector sampled at a rising clock edge appears on the outputs 4 rising edges later. Before that it has no effect on the outputs, and the delay does not depend on how many hits the vector holds.
- R3: When a crossing has at most 8 hits, exactly that many links are valid and every hit channel appears on exactly one of them.
- R4: Lower channel indices take lower link slots. Valid slot addresses rise strictly with slot number, and this holds across the group boundaries at channels 14/15 and 15/16.
- R5: Slots that receive no hit have valid 0 and address 0. Valid slots always form a contiguous run starting at slot 0.
- R6: When a crossing has more than 8 hits, the 8 lowest-indexed hit channels are sent, every other hit of that crossing is dropped, and `hitLost` is 1 for that crossing.
- R7: `hitLost` is 0 for any crossing with 8 or fewer hits, including exactly 8.
- R8: A new crossing is accepted on every clock. Slot usage and the loss flag never carry from one crossing into the next.
- R9: Slot s drives bits `linkAddr[5*s+4 : 5*s]` and `linkValid[s]`. The address is the plain binary channel index, 0 to 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hitIn | input | 31 | Hit flags of one crossing, bit i for channel i |
| linkAddr | output | 40 | Eight 5-bit channel addresses, slot s in bits 5*s+4 down to 5*s |
| linkValid | output | 8 | Valid bit per slot |
| hitLost | output | 1 | At least one hit of this crossing was dropped |

## Verification
The hardest case to reach is an overflow in which the slots run out partway through the chain. Examples are the ninth hit falling on the lone middle channel, or the enable being spent before the last group while that group still holds hits. A random vector rarely produces these. The stimulus therefore builds vectors with exact hit counts placed around the 14/15/16 boundaries, alongside exactly-eight and nine-hit cases. It drives them back to back with empty and dense crossings, so that any slot or loss state leaking between crossings shows up in the very next result.

// File: rtl/hitlink_pkg.sv
package hitlink_pkg;
  // sizing of the strip segment and of the output link bank
  localparam int CHAN_COUNT = 31;
  localparam int LINK_COUNT = 8;
  localparam int GROUPS     = 3;
  localparam int ADDR_W     = $clog2(CHAN_COUNT);
  localparam int SLOT_W     = $clog2(LINK_COUNT);
  // input register plus one register per group
  localparam int LATENCY    = GROUPS + 1;

  // one bank of link slots as it travels down the pipeline
  typedef struct packed {
    logic [LINK_COUNT-1:0]             valid;
    logic [LINK_COUNT-1:0][ADDR_W-1:0] addr;
  } slotBank_t;

  // strobes from the slot allocator to the datapath
  typedef struct packed {
    logic [CHAN_COUNT-1:0]             grant;
    logic [CHAN_COUNT-1:0][SLOT_W-1:0] slot;
    logic [GROUPS-1:0]                 drop;
  } allocStrobes_t;
endpackage

// File: rtl/hitlink_alloc.sv
module hitlink_alloc
  import hitlink_pkg::*;
#(
  parameter int GROUP1_FIRST = 15,
  parameter int GROUP2_FIRST = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CHAN_COUNT-1:0] stagedHits,
  output allocStrobes_t         strobes
);
  localparam int GROUP_LO [GROUPS] = '{0, GROUP1_FIRST, GROUP2_FIRST};
  localparam int GROUP_HI [GROUPS] = '{GROUP1_FIRST - 1, GROUP2_FIRST - 1, CHAN_COUNT - 1};
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LINK_COUNT - 1);

  logic [CHAN_COUNT-1:0]             grantAll;
  logic [CHAN_COUNT-1:0][SLOT_W-1:0] slotAll;
  logic [GROUPS-1:0]                 dropAll;

  for (genvar g = 0; g < GROUPS; g++) begin : gen_grp
    localparam int LO = GROUP_LO[g];
    localparam int HI = GROUP_HI[g];

    logic [SLOT_W-1:0]         startCnt;
    logic                      startEn;
    logic [SLOT_W-1:0]         gCnt;
    logic                      gEn;
    logic [HI:LO]              gGrant;
    logic [HI:LO][SLOT_W-1:0]  gSlot;
    logic                      gDrop;

    if (g == 0) begin : g_head
      assign startCnt = '0;
      assign startEn  = 1'b1;
    end else begin : g_link
      // count and enable handed over from the previous group, one cycle later
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startCnt <= '0;
          startEn  <= 1'b1;
        end else begin
          startCnt <= gen_grp[g-1].gCnt;
          startEn  <= gen_grp[g-1].gEn;
        end
      end
    end

    // increment chain over the channels of this group, lowest index first
    always_comb begin
      gCnt   = startCnt;
      gEn    = startEn;
      gGrant = '0;
      gSlot  = '0;
      gDrop  = 1'b0;
      for (int c = LO; c <= HI; c++) begin
        if (stagedHits[c]) begin
          if (gEn) begin
            gGrant[c] = 1'b1;
            gSlot[c]  = gCnt;
            if (gCnt == LAST_SLOT) gEn = 1'b0;
            gCnt = gCnt + 1'b1;
          end else begin
            gDrop = 1'b1;
          end
        end
      end
    end

    assign grantAll[HI:LO] = gGrant;
    assign slotAll[HI:LO]  = gSlot;
    assign dropAll[g]      = gDrop;
  end

  assign strobes.grant = grantAll;
  assign strobes.slot  = slotAll;
  assign strobes.drop  = dropAll;
endmodule

// File: rtl/hitlink_datapath.sv
module hitlink_datapath
  import hitlink_pkg::*;
#(
  parameter int GROUP1_FIRST = 15,
  parameter int GROUP2_FIRST = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CHAN_COUNT-1:0]        hitIn,
  input  allocStrobes_t                strobes,
  output logic [CHAN_COUNT-1:0]        stagedHits,
  output logic [LINK_COUNT*ADDR_W-1:0] linkAddr,
  output logic [LINK_COUNT-1:0]        linkValid,
  output logic                         hitLost
);
  localparam int GROUP_LO [GROUPS] = '{0, GROUP1_FIRST, GROUP2_FIRST};
  localparam int GROUP_HI [GROUPS] = '{GROUP1_FIRST - 1, GROUP2_FIRST - 1, CHAN_COUNT - 1};

  logic [CHAN_COUNT-1:0] hitReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitReg <= '0;
    else       hitReg <= hitIn;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gen_stage
    localparam int LO = GROUP_LO[g];
    localparam int HI = GROUP_HI[g];

    slotBank_t bankQ;
    logic      lostQ;
    slotBank_t prevBank;
    slotBank_t nextBank;
    logic      prevLost;

    // hit bits of group g wait g cycles to meet their crossing's count
    if (g == 0) begin : g_direct
      assign stagedHits[HI:LO] = hitReg[HI:LO];
    end else begin : g_delay
      logic [HI:LO] dly [g];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < g; k++) dly[k] <= '0;
        end else begin
          dly[0] <= hitReg[HI:LO];
          for (int k = 1; k < g; k++) dly[k] <= dly[k-1];
        end
      end
      assign stagedHits[HI:LO] = dly[g-1];
    end

    if (g == 0) begin : g_first
      assign prevBank = '0;
      assign prevLost = 1'b0;
    end else begin : g_chain
      assign prevBank = gen_stage[g-1].bankQ;
      assign prevLost = gen_stage[g-1].lostQ;
    end

    // enable-gated demultiplexer: each granted channel writes its slot
    always_comb begin
      nextBank = prevBank;
      for (int c = LO; c <= HI; c++) begin
        if (strobes.grant[c]) begin
          nextBank.valid[strobes.slot[c]] = 1'b1;
          nextBank.addr[strobes.slot[c]]  = ADDR_W'(c);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ <= '0;
        lostQ <= 1'b0;
      end else begin
        bankQ <= nextBank;
        lostQ <= prevLost | strobes.drop[g];
      end
    end
  end

  assign linkValid = gen_stage[GROUPS-1].bankQ.valid;
  assign linkAddr  = gen_stage[GROUPS-1].bankQ.addr;
  assign hitLost   = gen_stage[GROUPS-1].lostQ;
endmodule

// File: rtl/hitlink_top.sv
module hitlink_top
  import hitlink_pkg::*;
#(
  parameter int GROUP1_FIRST = 15,
  parameter int GROUP2_FIRST = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CHAN_COUNT-1:0]        hitIn,
  output logic [LINK_COUNT*ADDR_W-1:0] linkAddr,
  output logic [LINK_COUNT-1:0]        linkValid,
  output logic                         hitLost
);
  allocStrobes_t         strobes;
  logic [CHAN_COUNT-1:0] stagedHits;

  hitlink_alloc #(
    .GROUP1_FIRST(GROUP1_FIRST),
    .GROUP2_FIRST(GROUP2_FIRST)
  ) u_alloc (
    .clk       (clk),
    .rstN      (rstN),
    .stagedHits(stagedHits),
    .strobes   (strobes)
  );

  hitlink_datapath #(
    .GROUP1_FIRST(GROUP1_FIRST),
    .GROUP2_FIRST(GROUP2_FIRST)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .hitIn     (hitIn),
    .strobes   (strobes),
    .stagedHits(stagedHits),
    .linkAddr  (linkAddr),
    .linkValid (linkValid),
    .hitLost   (hitLost)
  );
endmodule

// File: rtl/hitlink_chk.sv
module hitlink_chk
  import hitlink_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [CHAN_COUNT-1:0]        hitIn,
  input logic [LINK_COUNT*ADDR_W-1:0] linkAddr,
  input logic [LINK_COUNT-1:0]        linkValid,
  input logic                         hitLost
);
  localparam int WARM_W = $clog2(LATENCY + 1);

  logic [WARM_W-1:0]     warm;
  logic [CHAN_COUNT-1:0] histQ [LATENCY];
  logic                  ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warm <= '0;
      for (int k = 0; k < LATENCY; k++) histQ[k] <= '0;
    end else begin
      if (warm != WARM_W'(LATENCY)) warm <= warm + 1'b1;
      histQ[0] <= hitIn;
      for (int k = 1; k < LATENCY; k++) histQ[k] <= histQ[k-1];
    end
  end

  assign ready = (warm == WARM_W'(LATENCY));

  // R1
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      reset_clear_chk: assert (linkValid == '0 && linkAddr == '0 && hitLost == 1'b0);
    end
  end

  // R3
  link_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> $countones(linkValid) ==
      (($countones($past(hitIn, LATENCY)) > LINK_COUNT) ? LINK_COUNT : $countones($past(hitIn, LATENCY))));

  // R6
  loss_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> hitLost == ($countones($past(hitIn, LATENCY)) > LINK_COUNT));

  // R7
  loss_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitLost |-> linkValid == '1);

  // R5
  contiguous_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid & (linkValid + 1'b1)) == '0);

  for (genvar s = 0; s < LINK_COUNT; s++) begin : gen_slot
    // R5
    idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      !linkValid[s] |-> linkAddr[s*ADDR_W +: ADDR_W] == '0);

    // R9
    addr_was_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ready && linkValid[s]) |-> histQ[LATENCY-1][linkAddr[s*ADDR_W +: ADDR_W]]);

    if (s > 0) begin : g_ord
      // R4
      ascending_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
        linkValid[s] |-> linkAddr[s*ADDR_W +: ADDR_W] > linkAddr[(s-1)*ADDR_W +: ADDR_W]);
    end
  end
endmodule

bind hitlink_top hitlink_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hitIn    (hitIn),
  .linkAddr (linkAddr),
  .linkValid(linkValid),
  .hitLost  (hitLost)
);

// File: tb/tb_hitlink_top.sv
module tb_hitlink_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH         = 31;
  localparam int LINKS      = 8;
  localparam int AW         = 5;
  localparam int PIPE_DEPTH = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CH-1:0]    hitIn;
  logic [LINKS*AW-1:0] linkAddr;
  logic [LINKS-1:0] linkValid;
  logic             hitLost;

  int checks   = 0;
  int failures = 0;

  logic [CH-1:0] expQ[$];
  string         tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hitlink_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .hitIn    (hitIn),
    .linkAddr (linkAddr),
    .linkValid(linkValid),
    .hitLost  (hitLost)
  );

  // behavioural reference: fill slots in ascending channel order, drop the rest
  task automatic compareNow(input logic [CH-1:0] v, input string tag);
    logic [LINKS-1:0]    ev;
    logic [LINKS*AW-1:0] ea;
    logic                el;
    int                  n;
    ev = '0; ea = '0; el = 1'b0; n = 0;
    for (int c = 0; c < CH; c++) begin
      if (v[c]) begin
        if (n < LINKS) begin
          ev[n] = 1'b1;
          ea[n*AW +: AW] = AW'(c);
          n++;
        end else begin
          el = 1'b1;
        end
      end
    end
    checks++;
    if (linkValid !== ev || linkAddr !== ea || hitLost !== el) begin
      failures++;
      $display("FAIL %s: in=%h valid=%h addr=%h lost=%b expected valid=%h addr=%h lost=%b",
               tag, v, linkValid, linkAddr, hitLost, ev, ea, el);
    end
  endtask

  task automatic step(input logic [CH-1:0] v, input string tag);
    @(negedge clk);
    compareNow(expQ.pop_front(), tagQ.pop_front());
    hitIn = v;
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  function automatic logic [CH-1:0] bitsOf(input int a, input int b);
    logic [CH-1:0] r;
    r = '0;
    for (int c = a; c <= b; c++) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL R2 watchdog: actual=timeout expected=finished run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < PIPE_DEPTH; k++) begin
      expQ.push_back('0);
      tagQ.push_back("R2");
    end
    rstN  = 1'b0;
    hitIn = '1;
    // R1: outputs held clear in reset even with every channel firing
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (linkValid !== '0 || linkAddr !== '0 || hitLost !== 1'b0) begin
        failures++;
        $display("FAIL R1: valid=%h addr=%h lost=%b expected valid=0 addr=0 lost=0",
                 linkValid, linkAddr, hitLost);
      end
    end
    @(negedge clk);
    rstN  = 1'b1;
    hitIn = '0;

    step('0, "R5");
    // R2: isolated hit surrounded by idle crossings, checked at every cycle
    step(31'h1, "R2");
    for (int k = 0; k < 5; k++) step('0, "R2");
    // R9: each channel alone lands in slot 0 with its own index
    for (int c = 0; c < CH; c++) step(CH'(1) << c, "R9");
    // R4: group boundaries
    step(bitsOf(14, 16), "R4");
    step(bitsOf(15, 15) | bitsOf(30, 30), "R4");
    step(bitsOf(16, 30) & 31'h2AAAAAAA, "R4");
    // R7: exactly eight hits spread over all groups
    step((CH'(1) << 1) | (CH'(1) << 4) | (CH'(1) << 9) | (CH'(1) << 14) |
         (CH'(1) << 15) | (CH'(1) << 20) | (CH'(1) << 25) | (CH'(1) << 30), "R7");
    step(bitsOf(0, 7), "R7");
    // R6: overflow at the middle channel, in the last group, and everywhere
    step(bitsOf(7, 15), "R6");
    step(bitsOf(0, 7) | bitsOf(15, 15) | bitsOf(30, 30), "R6");
    step(bitsOf(16, 30), "R6");
    step(bitsOf(10, 14) | bitsOf(20, 23), "R6");
    step('1, "R6");
    // R8: back-to-back crossings, dense then empty then sparse
    step('1, "R8");
    step('0, "R8");
    step('1, "R8");
    step(31'h40000000, "R8");
    step(31'h55555555, "R8");
    step(31'h00000003, "R8");
    // R3: varied densities
    for (int i = 0; i < 400; i++) begin
      logic [CH-1:0] r;
      r = CH'($urandom);
      case (i % 4)
        0: r = r & CH'($urandom) & CH'($urandom);
        1: r = r & CH'($urandom);
        2: r = r;
        default: r = r | CH'($urandom);
      endcase
      step(r, (i % 2 == 0) ? "R3" : "R8");
    end
    for (int k = 0; k < PIPE_DEPTH + 1; k++) step('0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule